// File: doc/BRIEF.md
# Interval Timer Host Access Port

This block is the byte-wide register port that a host uses to program and read a three-channel interval timer. A two-bit address picks one of the three channel data ports or the shared control port. Control writes either reprogram a channel, freezing a channel's count for later reading, or latch count and status for several channels at once. Data writes assemble a channel's 16-bit initial count, one or two bytes at a time. Data reads return a status byte, frozen count bytes or the live count, by a fixed priority.

The counting engines sit outside this block. For each channel, the port sends out a reprogram strobe, a load strobe with the assembled initial count, and the access, counting-mode and BCD fields. In return it takes in the channel's live count, its output level and its null-count flag. A read is combinational: read data is valid in the same cycle that the read strobe and address are presented, and all side effects of the read take place at the next clock edge.

Each channel has two small state machines, a write sequencer and a read sequencer. Each has the states HALF_LO (next byte is the low byte) and HALF_HI (next byte is the high byte). In access mode low-then-high, a data write moves HALF_LO to HALF_HI and then HALF_HI back to HALF_LO. A read of live count bytes moves the read sequencer the same way. A read of a frozen low byte moves the read sequencer to HALF_HI, and a read of a frozen high byte moves it back to HALF_LO. Any freeze of both count bytes forces the read sequencer back to HALF_LO. Reprogramming forces both sequencers to HALF_LO.

Top module: `timer_host_port`

## Requirements
- R1: A control word has the channel select in bits 7:6, access in bits 5:4 (1 = low byte only, 2 = high byte only, 3 = low then high), counting mode in bits 3:1 and BCD in bit 0. A word with select 0..2 and nonzero access reprograms that channel. The cycle after the write, ch_prog pulses for that channel, and ch_access, ch_mode and ch_bcd hold the new fields. Reset leaves access at 1, mode 0 and BCD 0.
- R2: In low-only access, a data byte d becomes initial count {0x00,d}. In high-only access, it becomes {d,0x00}. ch_load pulses in the cycle after the write, with ch_init_count valid in that same cycle.
- R3: In low-then-high access, the first data byte is the low byte and the second is the high byte. ch_load pulses only after the second byte, never after the first.
- R4: A control word with select 0..2 and access 0 freezes that channel's live count. Later reads return the frozen bytes even if the live count changes.
- R5: A count freeze request is ignored while any frozen count byte is still unread.
- R6: Select 3 is a multi-channel latch command. Bit 5 low freezes counts, bit 4 low freezes status, and bits 1, 2 and 3 pick channels 0, 1 and 2. In high-only access only the high byte is frozen, and in low-only access only the low byte.
- R7: The status byte is {output level, null-count flag, access[1:0], mode[2:0], BCD}, MSB first. A status freeze is ignored while an earlier frozen status is unread.
- R8: A channel read returns the frozen status first and clears it. Next come any frozen count bytes, low before high. Only when none remain does it return the live count.
- R9: In low-then-high access, live count reads alternate low and high. The read toggle is independent of the write toggle.
- R10: A count freeze taken while a two-byte read is half done restarts the read sequence at the low byte.
- R11: Reprogramming a channel discards its frozen status and count, and clears its pending initial count to 0.
- R12: A read of address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | 0..2 channel data port, 3 control port |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| ch_count | input | 48 | Live counts, channel i in bits 16i+15:16i |
| ch_out | input | 3 | Channel output levels |
| ch_null | input | 3 | Channel null-count flags |
| ch_prog | output | 3 | Reprogram strobes |
| ch_load | output | 3 | Initial-count load strobes |
| ch_init_count | output | 48 | Assembled initial counts |
| ch_access | output | 6 | Access fields, 2 bits per channel |
| ch_mode | output | 9 | Counting modes, 3 bits per channel |
| ch_bcd | output | 3 | BCD flags |

## Verification
Read data is due in the cycle in which the read strobe is high. The bench's monitor samples it a quarter period after the falling edge that raised the strobe, and compares it against the head of the expected-byte queue. The prog and load strobes, the captured fields and the initial count are due in the cycle after the write edge. Each write task checks them at the falling edge right after that edge, before the next access starts. Freezes take effect at the command's edge, so the first read after a command already sees them.

// File: rtl/timer_port_pkg.sv
package timer_port_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_LOHI  = 2'd3
    } access_e;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    typedef struct packed {
        logic [1:0]        sel;
        access_e           acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } ctrl_word_t;
endpackage

// File: rtl/timer_ctl_decode.sv
module timer_ctl_decode
    import timer_port_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NUM_CH-1:0] prog,
    output logic [NUM_CH-1:0] cnt_lat,
    output logic [NUM_CH-1:0] stat_lat,
    output access_e           cw_acc,
    output logic [MODE_W-1:0] cw_mode,
    output logic              cw_bcd
);
    localparam logic [1:0] SEL_MULTI = 2'd3;

    ctrl_word_t cw;
    logic       multi;

    assign cw      = ctrl_word_t'(wdata);
    assign cw_acc  = cw.acc;
    assign cw_mode = cw.mode;
    assign cw_bcd  = cw.bcd;
    assign multi   = wr_ctl && (cw.sel == SEL_MULTI);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit         = wr_ctl && (cw.sel == 2'(i));
        assign prog[i]     = hit && (cw.acc != ACC_LATCH);
        assign cnt_lat[i]  = (hit && (cw.acc == ACC_LATCH)) ||
                             (multi && !wdata[5] && wdata[i+1]);
        assign stat_lat[i] = multi && !wdata[4] && wdata[i+1];
    end

    assert_single_prog_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prog));
    assert_prog_excl_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prog & cnt_lat) == '0);
endmodule

// File: rtl/timer_chan_write.sv
module timer_chan_write
    import timer_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  access_e           cw_acc,
    input  logic [MODE_W-1:0] cw_mode,
    input  logic              cw_bcd,
    input  logic              wr_hit,
    input  logic [BYTE_W-1:0] wdata,
    output access_e           acc,
    output logic [MODE_W-1:0] mode,
    output logic              bcd,
    output logic [CNT_W-1:0]  init_count,
    output logic              load,
    output logic              prog_pulse
);
    half_e            wr_state, wr_nx;
    logic [CNT_W-1:0] init_nx;
    logic             load_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_state   <= HALF_LO;
            acc        <= ACC_LO;
            mode       <= '0;
            bcd        <= 1'b0;
            init_count <= '0;
            load       <= 1'b0;
            prog_pulse <= 1'b0;
        end else begin
            wr_state   <= wr_nx;
            init_count <= init_nx;
            load       <= load_nx;
            prog_pulse <= prog;
            if (prog) begin
                acc  <= cw_acc;
                mode <= cw_mode;
                bcd  <= cw_bcd;
            end
        end
    end

    always_comb begin
        wr_nx   = wr_state;
        init_nx = init_count;
        load_nx = 1'b0;
        if (prog) begin
            wr_nx   = HALF_LO;
            init_nx = '0;
        end else if (wr_hit) begin
            unique case (acc)
                ACC_LO: begin
                    init_nx = {{BYTE_W{1'b0}}, wdata};
                    load_nx = 1'b1;
                end
                ACC_HI: begin
                    init_nx = {wdata, {BYTE_W{1'b0}}};
                    load_nx = 1'b1;
                end
                ACC_LOHI: begin
                    unique case (wr_state)
                        HALF_LO: begin
                            init_nx = {{BYTE_W{1'b0}}, wdata};
                            wr_nx   = HALF_HI;
                        end
                        HALF_HI: begin
                            init_nx = {wdata, init_count[BYTE_W-1:0]};
                            wr_nx   = HALF_LO;
                            load_nx = 1'b1;
                        end
                        default: wr_nx = HALF_LO;
                    endcase
                end
                default: load_nx = 1'b0;
            endcase
        end
    end

    assert_no_half_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !prog && acc == ACC_LOHI && wr_state == HALF_LO) |=> !load);
    assert_load_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> $past(wr_hit));
    assert_prog_clears_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        prog |=> (init_count == '0) && (wr_state == HALF_LO));
endmodule

// File: rtl/timer_chan_read.sv
module timer_chan_read
    import timer_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  logic              cnt_lat,
    input  logic              stat_lat,
    input  logic              rd_hit,
    input  access_e           acc,
    input  logic [MODE_W-1:0] mode,
    input  logic              bcd,
    input  logic [CNT_W-1:0]  live_count,
    input  logic              out_lvl,
    input  logic              null_flag,
    output logic [BYTE_W-1:0] rdata
);
    half_e             rd_state, rd_nx;
    logic [CNT_W-1:0]  lat_val, lat_val_nx;
    logic              lat_lo_p, lat_lo_nx, lat_hi_p, lat_hi_nx;
    logic [BYTE_W-1:0] stat_val, stat_val_nx;
    logic              stat_p, stat_p_nx;
    half_e             live_half;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_state <= HALF_LO;
            lat_val  <= '0;
            lat_lo_p <= 1'b0;
            lat_hi_p <= 1'b0;
            stat_val <= '0;
            stat_p   <= 1'b0;
        end else begin
            rd_state <= rd_nx;
            lat_val  <= lat_val_nx;
            lat_lo_p <= lat_lo_nx;
            lat_hi_p <= lat_hi_nx;
            stat_val <= stat_val_nx;
            stat_p   <= stat_p_nx;
        end
    end

    always_comb begin
        unique case (acc)
            ACC_HI:   live_half = HALF_HI;
            ACC_LOHI: live_half = rd_state;
            default:  live_half = HALF_LO;
        endcase
        if (stat_p)
            rdata = stat_val;
        else if (lat_lo_p)
            rdata = lat_val[BYTE_W-1:0];
        else if (lat_hi_p)
            rdata = lat_val[CNT_W-1:BYTE_W];
        else if (live_half == HALF_HI)
            rdata = live_count[CNT_W-1:BYTE_W];
        else
            rdata = live_count[BYTE_W-1:0];
    end

    always_comb begin
        rd_nx       = rd_state;
        lat_val_nx  = lat_val;
        lat_lo_nx   = lat_lo_p;
        lat_hi_nx   = lat_hi_p;
        stat_val_nx = stat_val;
        stat_p_nx   = stat_p;
        if (prog) begin
            rd_nx     = HALF_LO;
            lat_lo_nx = 1'b0;
            lat_hi_nx = 1'b0;
            stat_p_nx = 1'b0;
        end else begin
            if (rd_hit) begin
                if (stat_p) begin
                    stat_p_nx = 1'b0;
                end else if (lat_lo_p) begin
                    lat_lo_nx = 1'b0;
                    if (acc == ACC_LOHI) rd_nx = HALF_HI;
                end else if (lat_hi_p) begin
                    lat_hi_nx = 1'b0;
                    if (acc == ACC_LOHI) rd_nx = HALF_LO;
                end else if (acc == ACC_LOHI) begin
                    unique case (rd_state)
                        HALF_LO: rd_nx = HALF_HI;
                        HALF_HI: rd_nx = HALF_LO;
                        default: rd_nx = HALF_LO;
                    endcase
                end
            end
            if (cnt_lat && !lat_lo_p && !lat_hi_p) begin
                lat_val_nx = live_count;
                unique case (acc)
                    ACC_HI: lat_hi_nx = 1'b1;
                    ACC_LOHI: begin
                        lat_lo_nx = 1'b1;
                        lat_hi_nx = 1'b1;
                        rd_nx     = HALF_LO;
                    end
                    default: lat_lo_nx = 1'b1;
                endcase
            end
            if (stat_lat && !stat_p) begin
                stat_val_nx = {out_lvl, null_flag, acc, mode, bcd};
                stat_p_nx   = 1'b1;
            end
        end
    end

    assert_count_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((lat_lo_p || lat_hi_p) && cnt_lat && !prog) |=> $stable(lat_val));
    assert_status_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_p && stat_lat && !prog) |=> $stable(stat_val));
    assert_prog_discards_R11: assert property (@(posedge clk) disable iff (!rst_n)
        prog |=> (!stat_p && !lat_lo_p && !lat_hi_p));
    assert_status_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && stat_p && !prog && !cnt_lat) |=>
            (!stat_p && $stable(lat_lo_p) && $stable(lat_hi_p)));
    assert_latch_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_lat && !prog && !lat_lo_p && !lat_hi_p && acc == ACC_LOHI) |=>
            (rd_state == HALF_LO && lat_lo_p && lat_hi_p));
endmodule

// File: rtl/timer_host_port.sv
module timer_host_port
    import timer_port_pkg::*;
#(
    parameter int NUM_CH = 3,
    localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [BYTE_W-1:0]          wdata,
    output logic [BYTE_W-1:0]          rdata,
    input  logic [NUM_CH*CNT_W-1:0]    ch_count,
    input  logic [NUM_CH-1:0]          ch_out,
    input  logic [NUM_CH-1:0]          ch_null,
    output logic [NUM_CH-1:0]          ch_prog,
    output logic [NUM_CH-1:0]          ch_load,
    output logic [NUM_CH*CNT_W-1:0]    ch_init_count,
    output logic [NUM_CH*2-1:0]        ch_access,
    output logic [NUM_CH*MODE_W-1:0]   ch_mode,
    output logic [NUM_CH-1:0]          ch_bcd
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH);

    logic [NUM_CH-1:0] prog, cnt_lat, stat_lat;
    access_e           cw_acc;
    logic [MODE_W-1:0] cw_mode;
    logic              cw_bcd;
    logic [BYTE_W-1:0] ch_rd [NUM_CH];

    timer_ctl_decode #(.NUM_CH(NUM_CH)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctl  (wr_en && (addr == CTL_ADDR)),
        .wdata   (wdata),
        .prog    (prog),
        .cnt_lat (cnt_lat),
        .stat_lat(stat_lat),
        .cw_acc  (cw_acc),
        .cw_mode (cw_mode),
        .cw_bcd  (cw_bcd)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        access_e           acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;

        timer_chan_write u_wr (
            .clk       (clk),
            .rst_n     (rst_n),
            .prog      (prog[i]),
            .cw_acc    (cw_acc),
            .cw_mode   (cw_mode),
            .cw_bcd    (cw_bcd),
            .wr_hit    (wr_en && (addr == ADDR_W'(i))),
            .wdata     (wdata),
            .acc       (acc),
            .mode      (mode),
            .bcd       (bcd),
            .init_count(ch_init_count[i*CNT_W +: CNT_W]),
            .load      (ch_load[i]),
            .prog_pulse(ch_prog[i])
        );

        timer_chan_read u_rd (
            .clk       (clk),
            .rst_n     (rst_n),
            .prog      (prog[i]),
            .cnt_lat   (cnt_lat[i]),
            .stat_lat  (stat_lat[i]),
            .rd_hit    (rd_en && (addr == ADDR_W'(i))),
            .acc       (acc),
            .mode      (mode),
            .bcd       (bcd),
            .live_count(ch_count[i*CNT_W +: CNT_W]),
            .out_lvl   (ch_out[i]),
            .null_flag (ch_null[i]),
            .rdata     (ch_rd[i])
        );

        assign ch_access[i*2 +: 2]          = acc;
        assign ch_mode[i*MODE_W +: MODE_W]  = mode;
        assign ch_bcd[i]                    = bcd;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (addr == ADDR_W'(i)) rdata = ch_rd[i];
    end

    assert_ctl_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == CTL_ADDR) |-> (rdata == '0));
endmodule

// File: tb/tb_timer_host_port.sv
module tb_timer_host_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] ch_count = '0;
    logic [2:0]  ch_out = '0, ch_null = '0;
    logic [2:0]  ch_prog, ch_load, ch_bcd;
    logic [47:0] ch_init_count;
    logic [5:0]  ch_access;
    logic [8:0]  ch_mode;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    timer_host_port dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .ch_count(ch_count), .ch_out(ch_out),
        .ch_null(ch_null), .ch_prog(ch_prog), .ch_load(ch_load),
        .ch_init_count(ch_init_count), .ch_access(ch_access), .ch_mode(ch_mode),
        .ch_bcd(ch_bcd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: compares read data against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (rd_en) begin
                if (exp_q.size() == 0) begin
                    check("read without expectation", 1, 0);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(t, rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        check("watchdog expired", 1, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1)
        check("R1 reset access", ch_access, 6'b010101);
        check("R1 reset mode", ch_mode, 0);
        check("R1 reset bcd", ch_bcd, 0);
        check("R2 reset load", ch_load, 0);
        check("R11 reset init count", ch_init_count, 0);

        // R1 program ch0: low-then-high, mode 2, binary
        wr(2'd3, 8'h34);
        check("R1 prog strobe", ch_prog, 3'b001);
        check("R1 access field", ch_access[1:0], 3);
        check("R1 mode field", ch_mode[2:0], 2);
        // R3 two-byte write
        wr(2'd0, 8'h34);
        check("R3 no load after first byte", ch_load, 0);
        wr(2'd0, 8'h12);
        check("R3 load after second byte", ch_load, 3'b001);
        check("R3 init count", ch_init_count[15:0], 16'h1234);

        // R2 high-only on ch1 (mode 0, BCD) and low-only on ch2 (mode 3)
        wr(2'd3, 8'h61);
        check("R1 bcd field", ch_bcd, 3'b010);
        wr(2'd1, 8'hAB);
        check("R2 high-only load", ch_load, 3'b010);
        check("R2 high-only count", ch_init_count[31:16], 16'hAB00);
        wr(2'd3, 8'h96);
        wr(2'd2, 8'h5C);
        check("R2 low-only load", ch_load, 3'b100);
        check("R2 low-only count", ch_init_count[47:32], 16'h005C);

        // R9 live reads alternate, independent of the write toggle
        ch_count[15:0] = 16'hBEEF;
        rd(2'd0, 8'hEF, "R9 live low");
        wr(2'd0, 8'h77);
        check("R3 no load mid sequence", ch_load, 0);
        rd(2'd0, 8'hBE, "R9 live high");
        rd(2'd0, 8'hEF, "R9 live low again");
        wr(2'd0, 8'h88);
        check("R3 completed count", ch_init_count[15:0], 16'h8877);

        // R10: read toggle is at high byte; freeze restarts at low
        // R4/R5: second freeze ignored while bytes unread
        ch_count[15:0] = 16'hCAFE;
        wr(2'd3, 8'h00);
        ch_count[15:0] = 16'h2222;
        wr(2'd3, 8'h00);
        rd(2'd0, 8'hFE, "R10 frozen low first");
        rd(2'd0, 8'hCA, "R5 frozen high kept");
        rd(2'd0, 8'h22, "R4 live after frozen");
        ch_count[15:0] = 16'h5678;
        wr(2'd3, 8'h00);
        rd(2'd0, 8'h78, "R10 restart low");
        rd(2'd0, 8'h56, "R4 frozen high");
        ch_count[15:0] = 16'h0102;
        rd(2'd0, 8'h02, "R10 live low after restart");
        rd(2'd0, 8'h01, "R9 live high");

        // R6/R7/R8 multi-channel latch of count and status for ch0, ch1
        ch_count[15:0]  = 16'h9ABC;
        ch_count[31:16] = 16'h4321;
        ch_count[47:32] = 16'h00F0;
        ch_out = 3'b001; ch_null = 3'b010;
        wr(2'd3, 8'hC6);
        ch_out = 3'b000; ch_null = 3'b000;
        wr(2'd3, 8'hE2);
        rd(2'd0, 8'hB4, "R7 status layout ch0 (second ignored)");
        rd(2'd0, 8'hBC, "R8 frozen low after status");
        rd(2'd0, 8'h9A, "R8 frozen high");
        rd(2'd0, 8'hBC, "R8 live when nothing frozen");
        ch_count[31:16] = 16'h7700;
        rd(2'd1, 8'h61, "R7 status with bcd ch1");
        rd(2'd1, 8'h43, "R6 high-only freeze");
        rd(2'd1, 8'h77, "R6 live high after freeze");
        rd(2'd2, 8'hF0, "R6 unselected channel live");

        // R11 reprogram discards frozen count and status
        wr(2'd3, 8'h80);
        wr(2'd3, 8'hE8);
        ch_count[47:32] = 16'h0033;
        wr(2'd3, 8'h96);
        check("R11 prog strobe", ch_prog, 3'b100);
        check("R11 pending count cleared", ch_init_count[47:32], 0);
        rd(2'd2, 8'h33, "R11 live after reprogram");

        // R12 control address read
        rd(2'd3, 8'h00, "R12 control read");

        repeat (3) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        summary();
    end
endmodule